// File: doc/BRIEF.md
# Single-Cycle Five-Operation Processor Core

This block is a small unpipelined processor core that completes one instruction on every rising clock edge. It knows a tiny load/store instruction subset: add an immediate to a register, branch when two registers differ, load a word, store a word, and a move that copies the low byte of a register onto an 8-bit host output. Any other instruction word is treated as a no-op.

The core fetches through an instruction port: it drives an address and reads back the instruction word in the same cycle. It reaches data through a second port: it drives address, write data, a direction flag and a valid strobe, and reads back data in the same cycle. Both memories sit outside the block and must answer combinationally. Inside are the program counter, a 32-entry register file, the sign extender, one adder shared by address, immediate and branch-target arithmetic, the decoder and the writeback selection. The decoder drives a small struct of strobes that steers the datapath.

Top module: `mini_core`

## Requirements
- R1: The major opcode is instruction bits [31:26]. 001001 is add-immediate, 000101 is branch-if-not-equal, 100011 is load word and 101011 is store word. 010000 with bits [25:21] equal to 00100 is the host move. The first source register rs is bits [25:21], the second register rt is bits [20:16], and the 16-bit immediate is bits [15:0].
- R2: Add-immediate writes R[rt] = R[rs] + sign-extended immediate at the clock edge.
- R3: Load word drives dmemValid=1 and dmemWrite=0, with dmemAddr = R[rs] + sign-extended immediate, and writes dmemRdata into R[rt] at the edge.
- R4: Store word drives dmemValid=1 and dmemWrite=1, with dmemAddr = R[rs] + sign-extended immediate and dmemWdata = R[rt]. It writes no register.
- R5: Branch-if-not-equal sets the next PC to PC+4 + (sign-extended immediate << 2) when R[rs] != R[rt], and to PC+4 when they are equal.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: The PC resets to 0x00001000. imemAddr always equals the current PC, and imemValid is always 1.
- R8: While rst is high, no data request is issued, no register is written, and the host output is held at 0.
- R9: The host move loads the low 8 bits of R[rt] into hostOut. hostOut keeps its value until the next host move.
- R10: Every opcode other than the five above, including 010000 with a different bits [25:21], is a no-op. It advances the PC by 4, writes no register, issues no data request and leaves hostOut unchanged. All non-branch instructions advance the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 32 | Instruction fetch address (current PC) |
| imemValid | output | 1 | Instruction request valid, constant 1 |
| imemData | input | 32 | Instruction word returned for imemAddr |
| dmemAddr | output | 32 | Data memory address |
| dmemWdata | output | 32 | Data memory write data |
| dmemWrite | output | 1 | 1 = write, 0 = read |
| dmemValid | output | 1 | Data memory request valid |
| dmemRdata | input | 32 | Data memory read data |
| hostOut | output | 8 | Host output byte |

## Verification
Immediate arithmetic is run with positive, negative and wide immediates, so sign extension and byte truncation on the host output are both exercised. Branches are run taken forward, not taken on equal registers, and backward inside a counted loop; together these separate the offset scaling, the PC+4 base and the comparison sense. Loads and stores use positive and negative offsets, and each data strobe is checked in its own cycle, which shows whether the direction flag and the address adder work. No-op words, a host move with the wrong sub-field, writes to register 0 and an instruction held under reset show whether any state changes when it must not.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;

  localparam logic [5:0] OP_ADDI  = 6'b001001;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_SYS   = 6'b010000;
  localparam logic [4:0] SYS_HOST = 5'b00100;

  typedef enum logic [2:0] {
    K_NOP, K_ADDI, K_BNE, K_LOAD, K_STORE, K_HOST
  } instKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeBranch; // next PC from adder instead of PC+4
    logic opAShift;   // operand A = imm<<2 instead of R[rs]
    logic opBPc;      // operand B = PC+4 instead of imm
    logic wbMem;      // writeback from memory instead of adder
    logic regWe;
    logic memValid;
    logic memWrite;
    logic hostEn;
  } coreCtl_t;

endpackage

// File: rtl/mini_core_regfile.sv
module mini_core_regfile #(
  parameter int W     = 32,
  parameter int COUNT = 32,
  localparam int AW   = $clog2(COUNT)
) (
  input  logic          clk,
  input  logic [AW-1:0] rAddrA,
  output logic [W-1:0]  rDataA,
  input  logic [AW-1:0] rAddrB,
  output logic [W-1:0]  rDataB,
  input  logic          wEn,
  input  logic [AW-1:0] wAddr,
  input  logic [W-1:0]  wData
);

  logic [W-1:0] regs [COUNT];

  always_ff @(posedge clk) begin
    if (wEn && (wAddr != '0)) regs[wAddr] <= wData;
  end

  assign rDataA = (rAddrA == '0) ? '0 : regs[rAddrA];
  assign rDataB = (rAddrB == '0) ? '0 : regs[rAddrB];

endmodule

// File: rtl/mini_core_ctrl.sv
module mini_core_ctrl
  import mini_core_pkg::*;
(
  input  logic        rst,
  input  logic [10:0] instHi,   // instruction bits [31:21]
  input  logic        srcEq,
  output coreCtl_t    ctl
);

  instKind_t kind;
  logic [5:0] opcode;
  logic [4:0] subFn;

  assign opcode = instHi[10:5];
  assign subFn  = instHi[4:0];

  always_comb begin
    unique case (opcode)
      OP_ADDI:  kind = K_ADDI;
      OP_BNE:   kind = K_BNE;
      OP_LOAD:  kind = K_LOAD;
      OP_STORE: kind = K_STORE;
      OP_SYS:   kind = (subFn == SYS_HOST) ? K_HOST : K_NOP;
      default:  kind = K_NOP;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (kind)
      K_ADDI:  ctl.regWe = 1'b1;
      K_BNE: begin
        ctl.opAShift   = 1'b1;
        ctl.opBPc      = 1'b1;
        ctl.takeBranch = ~srcEq;
      end
      K_LOAD: begin
        ctl.regWe    = 1'b1;
        ctl.wbMem    = 1'b1;
        ctl.memValid = 1'b1;
      end
      K_STORE: begin
        ctl.memValid = 1'b1;
        ctl.memWrite = 1'b1;
      end
      K_HOST:  ctl.hostEn = 1'b1;
      default: ;
    endcase
    if (rst) begin
      ctl.regWe    = 1'b0;
      ctl.memValid = 1'b0;
      ctl.hostEn   = 1'b0;
    end
  end

endmodule

// File: rtl/mini_core_dpath.sv
module mini_core_dpath
  import mini_core_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          REG_COUNT = 32,
  parameter int          HOST_W    = 8,
  parameter logic [31:0] RESET_PC  = 32'h0000_1000,
  localparam int         AW        = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            rst,
  input  coreCtl_t        ctl,
  input  logic [25:0]     fields,   // instruction bits [25:0]
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWdata,
  input  logic [XLEN-1:0] dmemRdata,
  output logic [HOST_W-1:0] hostOut,
  output logic            srcEq
);

  logic [AW-1:0]   rsIdx, rtIdx;
  logic [15:0]     imm;
  logic [XLEN-1:0] rsVal, rtVal, immExt, immShift;
  logic [XLEN-1:0] pcPlus4, opA, opB, sum, wbData, pcNext;

  assign rsIdx = fields[21 +: AW];
  assign rtIdx = fields[16 +: AW];
  assign imm   = fields[15:0];

  mini_core_regfile #(.W(XLEN), .COUNT(REG_COUNT)) rf (
    .clk(clk), .rAddrA(rsIdx), .rDataA(rsVal),
    .rAddrB(rtIdx), .rDataB(rtVal),
    .wEn(ctl.regWe), .wAddr(rtIdx), .wData(wbData)
  );

  assign immExt   = {{(XLEN-16){imm[15]}}, imm};
  assign immShift = immExt << 2;
  assign pcPlus4  = pc + XLEN'(4);

  assign opA = ctl.opAShift ? immShift : rsVal;
  assign opB = ctl.opBPc    ? pcPlus4  : immExt;
  assign sum = opA + opB;

  assign dmemAddr  = sum;
  assign dmemWdata = rtVal;
  assign wbData    = ctl.wbMem ? dmemRdata : sum;
  assign srcEq     = (rsVal == rtVal);
  assign pcNext    = ctl.takeBranch ? sum : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= XLEN'(RESET_PC);
    else     pc <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (rst)             hostOut <= '0;
    else if (ctl.hostEn) hostOut <= rtVal[HOST_W-1:0];
  end

endmodule

// File: rtl/mini_core.sv
module mini_core
  import mini_core_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          REG_COUNT = 32,
  parameter int          HOST_W    = 8,
  parameter logic [31:0] RESET_PC  = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   imemAddr,
  output logic              imemValid,
  input  logic [31:0]       imemData,
  output logic [XLEN-1:0]   dmemAddr,
  output logic [XLEN-1:0]   dmemWdata,
  output logic              dmemWrite,
  output logic              dmemValid,
  input  logic [XLEN-1:0]   dmemRdata,
  output logic [HOST_W-1:0] hostOut
);

  coreCtl_t ctl;
  logic     srcEq;

  mini_core_ctrl ctrl (
    .rst(rst), .instHi(imemData[31:21]), .srcEq(srcEq), .ctl(ctl)
  );

  mini_core_dpath #(
    .XLEN(XLEN), .REG_COUNT(REG_COUNT), .HOST_W(HOST_W), .RESET_PC(RESET_PC)
  ) dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .fields(imemData[25:0]),
    .pc(imemAddr), .dmemAddr(dmemAddr), .dmemWdata(dmemWdata),
    .dmemRdata(dmemRdata), .hostOut(hostOut), .srcEq(srcEq)
  );

  assign imemValid = 1'b1;
  assign dmemValid = ctl.memValid;
  assign dmemWrite = ctl.memWrite;

endmodule

// File: rtl/mini_core_chk.sv
module mini_core_chk
  import mini_core_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          HOST_W   = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   imemAddr,
  input logic              imemValid,
  input logic [31:0]       imemData,
  input logic              dmemWrite,
  input logic              dmemValid,
  input logic [HOST_W-1:0] hostOut,
  input coreCtl_t          ctl
);

  logic [5:0] op;
  logic [XLEN-1:0] brOff;
  logic isHost;
  assign op     = imemData[31:26];
  assign brOff  = {{(XLEN-16){imemData[15]}}, imemData[15:0]} << 2;
  assign isHost = (op == OP_SYS) && (imemData[25:21] == SYS_HOST);

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |-> (!dmemValid && !ctl.regWe && !ctl.hostEn));

  p_reset_pc_r7: assert property (@(posedge clk)
    rst |=> (imemAddr == XLEN'(RESET_PC) && hostOut == '0));

  p_fetch_valid_r7: assert property (@(posedge clk) imemValid);

  p_linear_pc_r10: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BNE) |=> (imemAddr == $past(imemAddr) + XLEN'(4)));

  p_branch_dest_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BNE) |=> (imemAddr == $past(imemAddr) + XLEN'(4) ||
                        imemAddr == $past(imemAddr) + XLEN'(4) + $past(brOff)));

  p_mem_only_ldst_r3: assert property (@(posedge clk) disable iff (rst)
    dmemValid |-> (op == OP_LOAD || op == OP_STORE));

  p_mem_dir_r4: assert property (@(posedge clk) disable iff (rst)
    dmemValid |-> (dmemWrite == (op == OP_STORE)));

  p_host_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !isHost |=> $stable(hostOut));

endmodule

bind mini_core mini_core_chk #(.XLEN(XLEN), .HOST_W(HOST_W), .RESET_PC(RESET_PC)) chk (
  .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemValid(imemValid),
  .imemData(imemData), .dmemWrite(dmemWrite), .dmemValid(dmemValid),
  .hostOut(hostOut), .ctl(ctl)
);

// File: tb/mini_core_test.sv
`timescale 1ns/1ps
module mini_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        imemValid, dmemWrite, dmemValid;
  logic [7:0]  hostOut;

  logic [31:0] prog [64];
  logic [31:0] dmem [64];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mini_core uut (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemValid(imemValid),
    .imemData(imemData), .dmemAddr(dmemAddr), .dmemWdata(dmemWdata),
    .dmemWrite(dmemWrite), .dmemValid(dmemValid), .dmemRdata(dmemRdata),
    .hostOut(hostOut)
  );

  always_comb begin
    if (imemAddr >= 32'h1000 && imemAddr < 32'h1100) imemData = prog[imemAddr[7:2]];
    else imemData = 32'h0;
  end
  assign dmemRdata = dmem[dmemAddr[7:2]];
  always @(posedge clk) if (dmemValid && dmemWrite) dmem[dmemAddr[7:2]] <= dmemWdata;

  function automatic logic [31:0] iAdd(int rt, int rs, int imm);
    return {6'b001001, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] iBne(int rs, int rt, int off);
    return {6'b000101, 5'(rs), 5'(rt), 16'(off)};
  endfunction
  function automatic logic [31:0] iLd(int rt, int rs, int off);
    return {6'b100011, 5'(rs), 5'(rt), 16'(off)};
  endfunction
  function automatic logic [31:0] iSt(int rt, int rs, int off);
    return {6'b101011, 5'(rs), 5'(rt), 16'(off)};
  endfunction
  function automatic logic [31:0] iHost(int rt);
    return {6'b010000, 5'b00100, 5'(rt), 16'h0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
  endtask

  task automatic startProg();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic testAddImm();
    clearProg();
    prog[0] = iAdd(1, 0, 5);
    prog[1] = iAdd(2, 1, -3);
    prog[2] = iHost(2);
    prog[3] = iAdd(3, 0, -1);
    prog[4] = iHost(3);
    prog[5] = iAdd(4, 0, 16'h1234);
    prog[6] = iHost(4);
    startProg();
    run(3); chk("R2 add positive then negative imm", hostOut, 8'h02);
    run(2); chk("R2 negative imm sign extension", hostOut, 8'hFF);
    run(2); chk("R9 low byte of wide value", hostOut, 8'h34);
  endtask

  task automatic testResetState();
    clearProg();
    prog[0] = iSt(0, 0, 0);
    dmem[0] = 32'hABCD;
    rst = 1'b1;
    run(3);
    chk("R7 reset PC", imemAddr, 32'h1000);
    chk("R7 fetch valid", 32'(imemValid), 32'd1);
    chk("R8 no data request in reset", 32'(dmemValid), 32'd0);
    chk("R8 host output cleared in reset", 32'(hostOut), 32'd0);
    chk("R8 memory untouched in reset", dmem[0], 32'hABCD);
  endtask

  task automatic testResetNoWrite();
    clearProg();
    prog[0] = iAdd(20, 0, 0);
    startProg();
    run(1);
    clearProg();
    prog[0] = iAdd(20, 20, 1);
    prog[1] = iHost(20);
    rst = 1'b1;
    run(3);
    rst = 1'b0;
    run(2);
    chk("R8 register write blocked in reset", 32'(hostOut), 32'd1);
  endtask

  task automatic testZeroReg();
    clearProg();
    prog[0] = iAdd(1, 0, 16'h66);
    prog[1] = iHost(1);
    prog[2] = iAdd(0, 0, 7);
    prog[3] = iHost(0);
    startProg();
    run(2); chk("R9 host move", hostOut, 8'h66);
    run(2); chk("R6 register 0 ignores write", hostOut, 8'h00);
  endtask

  task automatic testLoadStore();
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    clearProg();
    prog[0] = iAdd(1, 0, 16'h40);
    prog[1] = iAdd(2, 0, 16'h5A);
    prog[2] = iSt(2, 1, 8);
    prog[3] = iAdd(3, 0, -2);
    prog[4] = iSt(3, 1, -4);
    prog[5] = iLd(4, 1, 8);
    prog[6] = iHost(4);
    prog[7] = iLd(6, 1, -4);
    prog[8] = iHost(6);
    startProg();
    run(2);
    chk("R4 store valid", 32'(dmemValid), 32'd1);
    chk("R4 store direction", 32'(dmemWrite), 32'd1);
    chk("R4 store address", dmemAddr, 32'h48);
    chk("R4 store data", dmemWdata, 32'h5A);
    run(3);
    chk("R3 load valid", 32'(dmemValid), 32'd1);
    chk("R3 load direction", 32'(dmemWrite), 32'd0);
    chk("R3 load address", dmemAddr, 32'h48);
    run(2); chk("R3 loaded value written back", hostOut, 8'h5A);
    chk("R4 positive offset word", dmem[18], 32'h5A);
    chk("R4 negative offset word", dmem[15], 32'hFFFF_FFFE);
    run(2); chk("R3 load negative offset", hostOut, 8'hFE);
  endtask

  task automatic testBranchTaken();
    clearProg();
    prog[0] = iAdd(5, 0, 0);
    prog[1] = iAdd(1, 0, 1);
    prog[2] = iBne(1, 0, 1);
    prog[3] = iAdd(5, 5, 16'h11);
    prog[4] = iAdd(5, 5, 16'h22);
    prog[5] = iHost(5);
    startProg();
    run(3); chk("R5 taken forward target", imemAddr, 32'h1010);
    run(2); chk("R5 skipped instruction", hostOut, 8'h22);
  endtask

  task automatic testBranchNotTaken();
    clearProg();
    prog[0] = iAdd(5, 0, 0);
    prog[1] = iBne(0, 0, 1);
    prog[2] = iAdd(5, 5, 16'h11);
    prog[3] = iAdd(5, 5, 16'h22);
    prog[4] = iHost(5);
    startProg();
    run(2); chk("R5 equal falls through", imemAddr, 32'h1008);
    run(3); chk("R5 both instructions ran", hostOut, 8'h33);
  endtask

  task automatic testLoop();
    clearProg();
    prog[0] = iAdd(1, 0, 3);
    prog[1] = iAdd(2, 0, 0);
    prog[2] = iAdd(2, 2, 5);
    prog[3] = iAdd(1, 1, -1);
    prog[4] = iBne(1, 0, -3);
    prog[5] = iHost(2);
    startProg();
    run(5); chk("R5 backward branch target", imemAddr, 32'h1008);
    run(7); chk("R5 loop count", hostOut, 8'd15);
  endtask

  task automatic testNoOps();
    clearProg();
    prog[0] = iAdd(2, 0, 16'h11);
    prog[1] = iAdd(1, 0, 16'h2C);
    prog[2] = iHost(1);
    prog[3] = {6'b000000, 5'd1, 5'd2, 16'h0005};
    prog[4] = {6'b010000, 5'b00000, 5'd2, 16'h0};
    prog[5] = {6'b111111, 5'd1, 5'd2, 16'h0004};
    prog[6] = iHost(2);
    startProg();
    run(3);
    chk("R9 host value", hostOut, 8'h2C);
    chk("R10 no-op issues no data request", 32'(dmemValid), 32'd0);
    run(1); chk("R10 no-op advances PC", imemAddr, 32'h1010);
    run(1); chk("R10 wrong sub-field leaves host", hostOut, 8'h2C);
    run(2); chk("R10 no-op wrote no register", hostOut, 8'h11);
  endtask

  task automatic testFieldDecode();
    clearProg();
    prog[0] = iAdd(9, 0, 16'h7);
    prog[1] = iAdd(10, 9, 16'h30);
    prog[2] = iHost(10);
    startProg();
    run(3); chk("R1 rs/rt fields select registers", hostOut, 8'h37);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    clearProg();
    rst = 1'b1;
    testAddImm();
    testResetState();
    testResetNoWrite();
    testZeroReg();
    testFieldDecode();
    testLoadStore();
    testBranchTaken();
    testBranchNotTaken();
    testLoop();
    testNoOps();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule